// File: doc/BRIEF.md
# Field-Selective Register/Memory Transfer Unit

This block handles the data path of partial-word load and store operations on a sign-magnitude machine. A word is one sign bit followed by a row of bytes. An instruction picks a contiguous range of byte positions, with the sign optionally included. On a load, the block cuts that range out of a memory word, right-aligns it and produces the new register value. On a store, it places the low bytes of a register into the chosen positions of a memory word and leaves every other position as it was. Address generation, the memory array and opcode decoding sit outside the block.

Each request is one cycle wide. It carries an operation code, a register class, the field byte, the current memory word and the current register word. The block returns both candidate results and an illegal-field flag, all registered, one cycle later. Three register classes are supported: full word, short signed index register, and always-positive short jump register. Stores and loads of the full-word class treat the register as a whole word.

Top module: `fld_xfer`

## Requirements
- R1: Every request raises `out_valid` exactly one clock after `in_valid`. A cycle without a request gives `out_valid` low one clock later. Reset (synchronous, active high) clears `out_valid`, `illegal`, `load_result` and `store_result` to zero.
- R2: The field byte equals 8*first + last, with first in bits 5:3 and last in bits 2:0. Bits 7:6 must be zero. Position 0 is the sign and positions 1..5 are bytes, with position 1 the most significant. A legal field leaves `illegal` low.
- R3: A load (op 0) or negated load (op 1) places memory byte positions max(first,1)..last right-aligned in `load_result` and zero-fills the bytes above them.
- R4: The load sign (bit 30, 1 = negative) is the memory sign when first is 0 and positive otherwise.
- R5: A negated load inverts the sign that R4 would give.
- R6: A store (op 2) writes the register's rightmost last-max(first,1)+1 bytes into memory positions max(first,1)..last. The register's sign is written only when first is 0. All other memory bits keep their value in `store_result`.
- R7: A store-zero (op 3) clears only the selected positions, and the sign if first is 0, in `store_result`.
- R8: For the index class (tgt 1), a load keeps the sign and only the two low bytes, and a store uses only the register's sign and two low bytes.
- R9: For the jump class (tgt 2), a load gives a positive value from the two low bytes, including on a negated load. A store supplies a positive sign and the two low bytes. Classes 0 and 3 are full words.
- R10: A field with bits 7:6 nonzero, first > last, or last > 5 sets `illegal`, returns `reg_word` on `load_result` and returns `mem_word` on `store_result`.
- R11: A load returns `mem_word` unchanged on `store_result`. A store returns `reg_word` unchanged on `load_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 0 load, 1 negated load, 2 store, 3 store zero |
| tgt | input | 2 | Register class: 0 word, 1 index, 2 jump, 3 word |
| mod_byte | input | 8 | Field specification 8*first+last |
| mem_word | input | 31 | Current memory word (bit 30 sign) |
| reg_word | input | 31 | Current register word (bit 30 sign) |
| out_valid | output | 1 | Result strobe, one cycle after request |
| load_result | output | 31 | New register value |
| store_result | output | 31 | Merged memory word to write back |
| illegal | output | 1 | Field specification rejected |

## Verification
The properties compare each result with the inputs of the previous cycle. They assume `in_valid` is low during reset and that `op`, `tgt`, `mod_byte` and both words are held for the whole cycle in which `in_valid` is high. The stimulus drives all inputs on the falling edge and raises `in_valid` only after reset is released, so both assumptions hold. The sweep covers every 6-bit field code, several codes with the reserved top bits set, all four operations, all four register classes, and word patterns that mix signs, all-ones bytes and alternating bytes.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_LOADNEG = 2'd1,
    OP_STORE   = 2'd2,
    OP_STZERO  = 2'd3
  } fld_op_e;

  typedef enum logic [1:0] {
    TGT_WORD  = 2'd0,
    TGT_INDEX = 2'd1,
    TGT_JUMP  = 2'd2,
    TGT_WORD2 = 2'd3
  } fld_tgt_e;

  localparam int POS_W = 3;
endpackage

// File: rtl/fld_decode.sv
module fld_decode
  import fld_pkg::*;
#(
  parameter int NB = 5
) (
  input  logic [7:0]       mod_byte,
  output logic             legal,
  output logic             with_sign,
  output logic [POS_W-1:0] lo,
  output logic [POS_W-1:0] hi
);
  logic [POS_W-1:0] first;

  always_comb begin
    first     = mod_byte[5:3];
    hi        = mod_byte[2:0];
    with_sign = (first == '0);
    lo        = with_sign ? POS_W'(1) : first;
    legal     = (mod_byte[7:6] == 2'b00) && (first <= hi) && (int'(hi) <= NB);
  end
endmodule

// File: rtl/fld_load.sv
module fld_load
  import fld_pkg::*;
#(
  parameter int BW = 6,
  parameter int NB = 5,
  parameter int SB = 2
) (
  input  logic [NB*BW:0]    src,
  input  logic [POS_W-1:0]  lo,
  input  logic [POS_W-1:0]  hi,
  input  logic              with_sign,
  input  logic              negate,
  input  fld_tgt_e          tgt,
  output logic [NB*BW:0]    dst
);
  localparam int MW = NB * BW;
  logic [MW-1:0] mag;
  logic          sgn;

  always_comb begin
    mag = '0;
    // source position s lands hi-s bytes from the right
    for (int s = 1; s <= NB; s++) begin
      if (s >= int'(lo) && s <= int'(hi) && int'(hi) <= NB)
        mag[(int'(hi) - s)*BW +: BW] = src[(NB - s)*BW +: BW];
    end
    sgn = (with_sign ? src[MW] : 1'b0) ^ negate;
    if (tgt == TGT_INDEX || tgt == TGT_JUMP) begin
      for (int p = 1; p <= NB - SB; p++)
        mag[(NB - p)*BW +: BW] = '0;
    end
    if (tgt == TGT_JUMP) sgn = 1'b0;
    dst = {sgn, mag};
  end
endmodule

// File: rtl/fld_store.sv
module fld_store
  import fld_pkg::*;
#(
  parameter int BW = 6,
  parameter int NB = 5,
  parameter int SB = 2
) (
  input  logic [NB*BW:0]    mem,
  input  logic [NB*BW:0]    rsrc,
  input  logic [POS_W-1:0]  lo,
  input  logic [POS_W-1:0]  hi,
  input  logic              with_sign,
  input  logic              zero,
  input  fld_tgt_e          tgt,
  output logic [NB*BW:0]    merged
);
  localparam int MW = NB * BW;
  logic [MW:0] val;

  always_comb begin
    val = zero ? '0 : rsrc;
    if (!zero && (tgt == TGT_INDEX || tgt == TGT_JUMP)) begin
      for (int p = 1; p <= NB - SB; p++)
        val[(NB - p)*BW +: BW] = '0;
    end
    if (tgt == TGT_JUMP) val[MW] = 1'b0;

    merged = mem;
    // memory position p receives the register byte hi-p from the right
    for (int p = 1; p <= NB; p++) begin
      if (p >= int'(lo) && p <= int'(hi) && int'(hi) <= NB)
        merged[(NB - p)*BW +: BW] = val[(int'(hi) - p)*BW +: BW];
    end
    if (with_sign) merged[MW] = val[MW];
  end
endmodule

// File: rtl/fld_xfer.sv
module fld_xfer
  import fld_pkg::*;
#(
  parameter int BYTE_W      = 6,
  parameter int NUM_BYTES   = 5,
  parameter int SHORT_BYTES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [1:0]                    op,
  input  logic [1:0]                    tgt,
  input  logic [7:0]                    mod_byte,
  input  logic [NUM_BYTES*BYTE_W:0]     mem_word,
  input  logic [NUM_BYTES*BYTE_W:0]     reg_word,
  output logic                          out_valid,
  output logic [NUM_BYTES*BYTE_W:0]     load_result,
  output logic [NUM_BYTES*BYTE_W:0]     store_result,
  output logic                          illegal
);
  localparam int WORD_W = NUM_BYTES * BYTE_W + 1;

  fld_op_e          op_e;
  fld_tgt_e         tgt_e;
  logic             legal, with_sign;
  logic [POS_W-1:0] lo, hi;
  logic [WORD_W-1:0] ld_val, st_val, ld_next, st_next;
  logic              is_store;

  assign op_e     = fld_op_e'(op);
  assign tgt_e    = fld_tgt_e'(tgt);
  assign is_store = (op_e == OP_STORE) || (op_e == OP_STZERO);

  fld_decode #(.NB(NUM_BYTES)) u_dec (
    .mod_byte  (mod_byte),
    .legal     (legal),
    .with_sign (with_sign),
    .lo        (lo),
    .hi        (hi)
  );

  fld_load #(.BW(BYTE_W), .NB(NUM_BYTES), .SB(SHORT_BYTES)) u_ld (
    .src       (mem_word),
    .lo        (lo),
    .hi        (hi),
    .with_sign (with_sign),
    .negate    (op_e == OP_LOADNEG),
    .tgt       (tgt_e),
    .dst       (ld_val)
  );

  fld_store #(.BW(BYTE_W), .NB(NUM_BYTES), .SB(SHORT_BYTES)) u_st (
    .mem       (mem_word),
    .rsrc      (reg_word),
    .lo        (lo),
    .hi        (hi),
    .with_sign (with_sign),
    .zero      (op_e == OP_STZERO),
    .tgt       (tgt_e),
    .merged    (st_val)
  );

  always_comb begin
    ld_next = reg_word;
    st_next = mem_word;
    if (legal) begin
      if (is_store) st_next = st_val;
      else          ld_next = ld_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      illegal      <= 1'b0;
      load_result  <= '0;
      store_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal      <= !legal;
        load_result  <= ld_next;
        store_result <= st_next;
      end
    end
  end
endmodule

// File: rtl/fld_xfer_chk.sv
module fld_xfer_chk #(
  parameter int W  = 31,
  parameter int NB = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   op,
  input logic [1:0]   tgt,
  input logic [7:0]   mod_byte,
  input logic [W-1:0] mem_word,
  input logic [W-1:0] reg_word,
  input logic         out_valid,
  input logic [W-1:0] load_result,
  input logic [W-1:0] store_result,
  input logic         illegal
);
  logic fld_ok;
  assign fld_ok = (mod_byte[7:6] == 2'b00) && (mod_byte[5:3] <= mod_byte[2:0])
                  && (int'(mod_byte[2:0]) <= NB);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_BAD_LAST_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int'(mod_byte[2:0]) > NB) |=> illegal); // R10
  AST_REVERSED_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mod_byte[5:3] > mod_byte[2:0]) |=>
      (illegal && store_result == $past(mem_word) && load_result == $past(reg_word))); // R10
  AST_LOAD_KEEPS_MEM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op[1]) |=> store_result == $past(mem_word)); // R11
  AST_STORE_KEEPS_REG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[1]) |=> load_result == $past(reg_word)); // R11
  AST_JUMP_LOAD_POS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fld_ok && !op[1] && tgt == 2'd2) |=> !load_result[W-1]); // R9
  AST_NOSIGN_LOAD_POS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fld_ok && op == 2'd0 && mod_byte[5:3] != 3'd0) |=> !load_result[W-1]); // R4
  AST_STORE_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[1] && mod_byte[5:3] != 3'd0) |=> store_result[W-1] == $past(mem_word[W-1])); // R6
endmodule

bind fld_xfer fld_xfer_chk #(.W(WORD_W), .NB(NUM_BYTES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .op           (op),
  .tgt          (tgt),
  .mod_byte     (mod_byte),
  .mem_word     (mem_word),
  .reg_word     (reg_word),
  .out_valid    (out_valid),
  .load_result  (load_result),
  .store_result (store_result),
  .illegal      (illegal)
);

// File: tb/tb_fld_xfer.sv
module tb_fld_xfer;
  localparam int W = 31;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   op = '0;
  logic [1:0]   tgt = '0;
  logic [7:0]   mod_byte = '0;
  logic [W-1:0] mem_word = '0;
  logic [W-1:0] reg_word = '0;
  logic         out_valid, illegal;
  logic [W-1:0] load_result, store_result;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fld_xfer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .tgt(tgt),
    .mod_byte(mod_byte), .mem_word(mem_word), .reg_word(reg_word),
    .out_valid(out_valid), .load_result(load_result),
    .store_result(store_result), .illegal(illegal)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic longint pw(input int nbytes);
    return longint'(1) << (6 * nbytes);
  endfunction

  task automatic model(input int o, input int t, input int md,
                       input logic [W-1:0] m, input logic [W-1:0] r,
                       output logic [W-1:0] eld, output logic [W-1:0] est,
                       output bit ebad);
    int f, l, lo, nb;
    longint mm, rm, v, sc, fw, old, nm;
    logic s, rs;
    f = (md >> 3) & 7;
    l = md & 7;
    ebad = ((md >> 6) != 0) || (f > l) || (l > 5);
    eld = r;
    est = m;
    if (ebad) return;
    lo = (f == 0) ? 1 : f;
    nb = l - lo + 1;
    sc = pw(5 - l);
    fw = pw(nb);
    mm = longint'(m[29:0]);
    rm = longint'(r[29:0]);
    if (o < 2) begin
      v = (mm / sc) % fw;
      s = (f == 0) ? m[30] : 1'b0;
      if (o == 1) s = ~s;
      if (t == 1) v = v % pw(2);
      if (t == 2) begin v = v % pw(2); s = 1'b0; end
      eld = {s, v[29:0]};
    end else begin
      rs = r[30];
      if (o == 3) begin rs = 1'b0; rm = 0; end
      else if (t == 1) rm = rm % pw(2);
      else if (t == 2) begin rm = rm % pw(2); rs = 1'b0; end
      old = (mm / sc) % fw;
      nm  = mm - old * sc + (rm % fw) * sc;
      est = {(f == 0) ? rs : m[30], nm[29:0]};
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] pm [4];
    logic [W-1:0] pr [4];
    logic [W-1:0] eld, est;
    bit ebad;
    int mods [67];
    string tl, ts;

    pm[0] = {1'b1, 30'h2AAA_AAAA}; pr[0] = {1'b0, 30'h1555_5555};
    pm[1] = {1'b0, 30'h0123_4567}; pr[1] = {1'b1, 30'h3FFF_FFFF};
    pm[2] = {1'b1, 30'h3FFF_FFFF}; pr[2] = {1'b1, 30'h0000_0FC1};
    pm[3] = {1'b0, 30'h0000_0000}; pr[3] = {1'b0, 30'h2D4B_3C99};
    for (int i = 0; i < 64; i++) mods[i] = i;
    mods[64] = 64 + 5; mods[65] = 128 + 13; mods[66] = 192;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!out_valid && !illegal && load_result == '0 && store_result == '0,
          "R1 reset", {out_valid, illegal}, 0);

    for (int pi = 0; pi < 4; pi++)
      for (int mi = 0; mi < 67; mi++)
        for (int o = 0; o < 4; o++)
          for (int t = 0; t < 4; t++) begin
            in_valid = 1'b1;
            op = 2'(o); tgt = 2'(t); mod_byte = 8'(mods[mi]);
            mem_word = pm[pi]; reg_word = pr[pi];
            model(o, t, mods[mi], pm[pi], pr[pi], eld, est, ebad);
            @(negedge clk);
            check(out_valid == 1'b1, "R1 valid", out_valid, 1);
            check(illegal == ebad, ebad ? "R10 flag" : "R2 flag", illegal, ebad);
            if (ebad) begin
              check(load_result == eld, "R10 load", load_result, eld);
              check(store_result == est, "R10 store", store_result, est);
            end else if (o < 2) begin
              tl = (t == 1) ? "R8 load" : (t == 2) ? "R9 load" : "R3 load";
              check(load_result[29:0] == eld[29:0], tl, load_result, eld);
              ts = (t == 2) ? "R9 sign" : (o == 1) ? "R5 sign" : "R4 sign";
              check(load_result[30] == eld[30], ts, load_result[30], eld[30]);
              check(store_result == est, "R11 store", store_result, est);
            end else begin
              ts = (o == 3) ? "R7 store" : (t == 1) ? "R8 store" : (t == 2) ? "R9 store" : "R6 store";
              check(store_result == est, ts, store_result, est);
              check(load_result == eld, "R11 load", load_result, eld);
            end
          end

    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 idle", out_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule